// File: doc/BRIEF.md
# Edge-Triggered NMI/SMI Request Latch

This block turns two asynchronous interrupt pins into clean, sticky requests for an instruction sequencer. The non-maskable interrupt pin is active high and fires on its rising edge. The system-management pin is active low and fires on its falling edge. Each pin first passes through a two-flop synchronizer. An edge detector then sets a pending flag, so the pin may drop again long before the request is serviced.

The sequencer raises `boundary` whenever it can take an interrupt. In that same cycle the block answers with at most one accept pulse. System management is preferred over NMI. Accepting an NMI masks further NMI service until the sequencer pulses `iret`. While the mask is set, any number of new NMI edges collapse into a single held request, which is offered again once the mask lifts. The NMI edge detector re-arms only after the pin has been seen low for a minimum run of clocks. A rising edge after a shorter gap is ignored.

Top module: `irq_edge_latch`

## Requirements
- R1: Each pin goes through two synchronizer flops and an edge register. A pin change applied before rising edge 1 shows on the request output after rising edge 3, and not after rising edge 2.
- R2: A rising edge on `nmi_pin` (0 to 1) sets the NMI pending flag. A high pulse lasting a single clock is enough.
- R3: Holding `nmi_pin` high for any number of clocks produces exactly one NMI request.
- R4: A rising edge of `nmi_pin` creates a request only if the pin was low for at least 4 consecutive clocks before it. After a low gap of 3 clocks, the edge creates no request.
- R5: A falling edge on `smi_pin_n` (1 to 0) sets the SMI pending flag. A single low clock is enough, and holding the pin low for any number of clocks gives exactly one request. SMI has no re-arm gap.
- R6: Pending flags are sticky. A flag clears only when its accept pulse (`smi_take` or `nmi_take`) fires, and an accept can fire only while `boundary` is 1.
- R7: At most one accept fires per cycle. When both requests are pending at a boundary, `smi_take` fires first, and the NMI is accepted at a later boundary.
- R8: `nmi_take` sets `nmi_masked` from the next cycle on. While it is masked, `nmi_req` is 0 and `nmi_take` cannot fire. The mask clears only on the clock edge that samples `iret` high. If `nmi_take` and `iret` are high together, the mask is set.
- R9: NMI edges that arrive while the mask is set are held as one pending request. After `iret`, exactly one further NMI is accepted.
- R10: Reset clears the synchronizers, both pending flags and the mask. It leaves the NMI detector armed, so a rising edge right after reset is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous NMI pin, active high |
| smi_pin_n | input | 1 | Asynchronous SMI pin, active low |
| boundary | input | 1 | Sequencer is at a point where it can accept an interrupt |
| iret | input | 1 | Return-from-interrupt strobe; clears the NMI mask |
| smi_req | output | 1 | SMI request pending |
| nmi_req | output | 1 | NMI request pending and not masked |
| smi_take | output | 1 | SMI accepted this cycle |
| nmi_take | output | 1 | NMI accepted this cycle |
| nmi_masked | output | 1 | NMI service mask is set |

## Verification
An SMI request and an NMI request can both be pending at the same boundary cycle, and only one of them may be accepted there. The bench provokes this by leaving the pins' requests unaccepted and raising `boundary` once both are pending. It then checks that `smi_take` alone fires in that cycle and that `nmi_take` follows alone on the next boundary. The table walk holds `boundary` and `iret` high throughout. As a result, an accept and an NMI edge, or an accept and a return, can land in the same cycle, and the number of accepts is compared with the count that R3 to R5 predict.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_SMI  = 2'd1,
    GNT_NMI  = 2'd2
  } grant_e;

  // Fixed preference: system management before NMI, nothing off-boundary.
  function automatic grant_e pick_grant(input logic at_bnd,
                                        input logic smi_pending,
                                        input logic nmi_ready);
    if (!at_bnd)          return GNT_NONE;
    else if (smi_pending) return GNT_SMI;
    else if (nmi_ready)   return GNT_NMI;
    else                  return GNT_NONE;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_rise_det.sv
module nmi_rise_det #(
  parameter int REARM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  localparam int CW = $clog2(REARM + 1);
  localparam logic [CW-1:0] FULL = CW'(REARM);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == FULL) ? v : v + 1'b1;
  endfunction

  logic [CW-1:0] low_run;
  logic          armed;

  assign armed = (low_run == FULL);
  assign rise  = lvl && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)   low_run <= FULL;
    else if (lvl) low_run <= '0;
    else          low_run <= sat_inc(low_run);
  end

  // R3: a held-high level gives one detection, never two in a row
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/smi_fall_det.sv
module smi_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  output logic fall
);
  logic prev_n;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= lvl_n;
  end

  assign fall = prev_n && !lvl_n;

  // R5: a long low level gives one detection
  a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
  import irq_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NMI_REARM   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic smi_pin_n,
  input  logic boundary,
  input  logic iret,
  output logic smi_req,
  output logic nmi_req,
  output logic smi_take,
  output logic nmi_take,
  output logic nmi_masked
);
  logic   nmi_s, smi_s_n;
  logic   nmi_rise, smi_fall;
  logic   smi_pend, nmi_pend, nmi_mask;
  logic   nmi_ready;
  grant_e grant;

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .d(nmi_pin), .q(nmi_s));

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_smi (
    .clk(clk), .rst_n(rst_n), .d(smi_pin_n), .q(smi_s_n));

  nmi_rise_det #(.REARM(NMI_REARM)) u_nmi_det (
    .clk(clk), .rst_n(rst_n), .lvl(nmi_s), .rise(nmi_rise));

  smi_fall_det u_smi_det (
    .clk(clk), .rst_n(rst_n), .lvl_n(smi_s_n), .fall(smi_fall));

  assign nmi_ready = nmi_pend && !nmi_mask;
  assign grant     = pick_grant(boundary, smi_pend, nmi_ready);
  assign smi_take  = (grant == GNT_SMI);
  assign nmi_take  = (grant == GNT_NMI);

  // A new edge wins over a same-cycle accept, so it is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_pend <= 1'b0;
      nmi_pend <= 1'b0;
      nmi_mask <= 1'b0;
    end else begin
      smi_pend <= (smi_pend && !smi_take) || smi_fall;
      nmi_pend <= (nmi_pend && !nmi_take) || nmi_rise;
      if (nmi_take)  nmi_mask <= 1'b1;
      else if (iret) nmi_mask <= 1'b0;
    end
  end

  assign smi_req    = smi_pend;
  assign nmi_req    = nmi_ready;
  assign nmi_masked = nmi_mask;

  // R6: accepts only at a boundary; unaccepted requests persist
  a_r6_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_take || nmi_take) |-> boundary);
  a_r6_smi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smi_take) |=> smi_req);
  // R7: one accept per cycle, SMI first
  a_r7_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smi_take, nmi_take}));
  a_r7_smi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && smi_req) |-> (smi_take && !nmi_take));
  // R8: accepting masks; the mask holds until the return strobe
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (nmi_masked && !nmi_req));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_masked && !iret) |=> nmi_masked);
  a_r8_no_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_masked |-> !nmi_take);
  // R9: an edge held under the mask is kept until the mask lifts
  a_r9_held_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_masked && nmi_pend) |=> nmi_pend);
endmodule

// File: tb/irq_edge_latch_bench.sv
`timescale 1ns/1ps
module irq_edge_latch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b0, smi_pin_n = 1'b1, boundary = 1'b0, iret = 1'b0;
  logic smi_req, nmi_req, smi_take, nmi_take, nmi_masked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_edge_latch u_irq_edge_latch (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .smi_pin_n(smi_pin_n),
    .boundary(boundary), .iret(iret), .smi_req(smi_req), .nmi_req(nmi_req),
    .smi_take(smi_take), .nmi_take(nmi_take), .nmi_masked(nmi_masked));

  // fields: pin select (0 nmi, 1 smi), first assert length, inactive gap,
  // second assert length, expected number of accepts
  localparam logic [39:0] VEC [7] = '{
    {8'd0, 8'd1,  8'd3, 8'd1,  8'd1},   // R4 gap 3 ignored
    {8'd0, 8'd1,  8'd4, 8'd1,  8'd2},   // R4 gap 4 re-arms
    {8'd0, 8'd40, 8'd0, 8'd0,  8'd1},   // R3 long hold
    {8'd0, 8'd1,  8'd6, 8'd30, 8'd2},   // R2 short then long
    {8'd1, 8'd1,  8'd0, 8'd0,  8'd1},   // R5 single low clock
    {8'd1, 8'd35, 8'd1, 8'd1,  8'd2},   // R5 long low, short gap
    {8'd1, 8'd1,  8'd3, 8'd40, 8'd2}    // R5 short then long
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; nmi_pin = 1'b0; smi_pin_n = 1'b1; boundary = 1'b0; iret = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic nmi_pulse(input int gap);
    nmi_pin = 1'b1; cyc(); nmi_pin = 1'b0;
    repeat (gap) cyc();
  endtask

  initial begin
    reset_dut();
    #1;
    check("R10 reset smi_req", smi_req, 0);
    check("R10 reset nmi_req", nmi_req, 0);
    check("R10 reset nmi_masked", nmi_masked, 0);

    for (int i = 0; i < 7; i++) begin
      int sel, h1, gap, h2, exp, n, total;
      sel = VEC[i][39:32]; h1 = VEC[i][31:24]; gap = VEC[i][23:16];
      h2 = VEC[i][15:8]; exp = VEC[i][7:0];
      reset_dut();
      boundary = 1'b1; iret = 1'b1;
      n = 0;
      total = h1 + gap + h2 + 12;
      for (int t = 0; t < total; t++) begin
        logic on;
        on = (t < h1) || (t >= h1 + gap && t < h1 + gap + h2);
        if (sel == 0) nmi_pin = on; else smi_pin_n = !on;
        #1;
        n += (sel == 0) ? int'(nmi_take) : int'(smi_take);
        cyc();
      end
      boundary = 1'b0; iret = 1'b0;
      check($sformatf("R2 R3 R4 R5 vector %0d accepts", i), n, exp);
    end

    // R1 latency and R6 stickiness
    reset_dut();
    smi_pin_n = 1'b0; cyc(); smi_pin_n = 1'b1;
    cyc(); #1;
    check("R1 smi_req after edge 2", smi_req, 0);
    cyc(); #1;
    check("R1 smi_req after edge 3", smi_req, 1);
    repeat (5) cyc(); #1;
    check("R6 smi_req sticky", smi_req, 1);
    check("R6 no take off boundary", smi_take, 0);

    // R7 both pending at one boundary
    nmi_pulse(4); #1;
    check("R7 nmi_req pending", nmi_req, 1);
    boundary = 1'b1; #1;
    check("R7 smi_take first", smi_take, 1);
    check("R7 nmi_take held back", nmi_take, 0);
    cyc(); #1;
    check("R7 nmi_take next boundary", nmi_take, 1);
    check("R7 smi_take cleared", smi_take, 0);
    cyc(); boundary = 1'b0; #1;
    check("R8 masked after take", nmi_masked, 1);

    // R8 and R9 edges under mask
    nmi_pulse(6);
    nmi_pulse(6);
    repeat (4) cyc(); #1;
    check("R8 nmi_req low while masked", nmi_req, 0);
    boundary = 1'b1; #1;
    check("R8 no take while masked", nmi_take, 0);
    cyc(); boundary = 1'b0; iret = 1'b1; cyc(); iret = 1'b0; #1;
    check("R8 mask cleared by iret", nmi_masked, 0);
    check("R9 held nmi offered", nmi_req, 1);
    boundary = 1'b1; #1;
    check("R9 held nmi accepted", nmi_take, 1);
    cyc(); boundary = 1'b0; iret = 1'b1; cyc(); iret = 1'b0; #1;
    check("R9 only one held", nmi_req, 0);

    // R10 reset clears pending and mask
    nmi_pulse(4);
    boundary = 1'b1; cyc(); boundary = 1'b0;
    smi_pin_n = 1'b0; cyc(); smi_pin_n = 1'b1;
    repeat (4) cyc(); #1;
    check("R10 pre-reset mask", nmi_masked, 1);
    check("R10 pre-reset smi", smi_req, 1);
    reset_dut(); #1;
    check("R10 smi cleared", smi_req, 0);
    check("R10 mask cleared", nmi_masked, 0);
    nmi_pin = 1'b1; cyc(); nmi_pin = 1'b0;
    cyc(); cyc(); #1;
    check("R10 armed after reset", nmi_req, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule